// File: doc/BRIEF.md
# Paging Codeword Error Corrector

This block repairs one received 32-bit paging codeword at a time and labels the result with an error class. The word is protected by a shortened cyclic (31,21) BCH code and an extra even-parity bit that covers all 32 bits. Random correction of one or two wrong bits is always active. A configuration input adds a second mode that also repairs three wrong bits that fall inside any window of four adjacent positions. Address words and message words get the same correction. For address words the block also returns the two call-type bits as they appear in the corrected word.

A receiver front end presents a word together with a one-cycle valid strobe, a flag that marks it as an address word, and the burst-enable setting. The corrected word, its class and the call type appear together with a one-cycle done pulse a fixed time later. Downstream logic can then drop words that are classed uncorrectable, or that needed too many repairs.

Top module: `paging_cw_corrector`

## Requirements
- R1: A word is taken when `in_valid` is high at a rising edge while no word is pending. `out_done` goes high for exactly one cycle on the next rising edge, and is low after the accepting edge itself. A strobe at the edge where `out_done` rises is ignored and produces no result.
- R2: Bit layout: `in_word[31]` is the first bit sent, `in_word[31:1]` is a BCH codeword with generator x^10+x^9+x^8+x^6+x^5+x^3+1 (`in_word[31:11]` data, `in_word[10:1]` check bits), and `in_word[0]` makes the 32-bit parity even. An error-free word is returned unchanged with class 000.
- R3: A word with any single wrong bit among the 32 is returned repaired with class 001.
- R4: A word with any two wrong bits among the 32, including the parity bit, is returned repaired with class 010.
- R5: With `cfg_burst_en` = 1, a word with three wrong bits that all lie inside one window of four adjacent positions is returned repaired with class 011.
- R6: With `cfg_burst_en` = 0, any word with exactly three wrong bits, including ones inside a four-bit window, is returned unchanged with class 111.
- R7: For an address word, `out_call_type` equals corrected bits `{out_word[12], out_word[11]}` (00 numeric, 01 alert-only 1, 10 alert-only 2, 11 alphanumeric), and every code is passed through unchecked.
- R8: For a message word, `out_call_type` is 00. The corrected word and class follow the same rules as for address words.
- R9: After reset, `out_done` is 0, `out_word` is 0, `out_class` is 000 and `out_call_type` is 00.
- R10: With `cfg_burst_en` = 1, words with one or two wrong bits still get class 001 or 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe: a word is presented |
| in_word | input | 32 | Received codeword |
| in_is_addr | input | 1 | 1 = address word, 0 = message word |
| cfg_burst_en | input | 1 | 1 = also repair 3 errors inside a 4-bit window |
| out_done | output | 1 | One-cycle result strobe |
| out_word | output | 32 | Corrected codeword, or the input unchanged if uncorrectable |
| out_class | output | 3 | 000 none, 001 one, 010 two, 011 burst, 111 uncorrectable |
| out_call_type | output | 2 | Call-type bits of an address word, 00 for message words |

## Verification
The bench builds the block with its default window of four positions and a burst limit of three wrong bits. With these values every single-bit position, a spread of two-bit pairs and every three-bit pattern in all 29 window placements can be reached, in both settings of the burst enable. The bench also sends a strobe while a word is pending, to show that it is ignored.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int CW_W  = 32;
  localparam int CHK_W = 10;
  localparam int BCH_N = CW_W - 1;
  localparam logic [CHK_W:0] GEN_POLY = 11'b111_0110_1001;

  // positions of the two call-type bits in the 32-bit word
  localparam int CALL_HI = CW_W - 20;
  localparam int CALL_LO = CW_W - 21;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'b000,
    ERR_ONE   = 3'b001,
    ERR_TWO   = 3'b010,
    ERR_BURST = 3'b011,
    ERR_FAIL  = 3'b111
  } err_class_e;

  // remainder of v(x)*x^CHK_W modulo the generator; zero for every codeword
  function automatic logic [CHK_W-1:0] bch_syndrome(input logic [BCH_N-1:0] v);
    logic [CHK_W-1:0] r;
    logic             fb;
    r = '0;
    for (int i = BCH_N - 1; i >= 0; i--) begin
      fb = r[CHK_W-1] ^ v[i];
      r  = {r[CHK_W-2:0], 1'b0};
      if (fb) r = r ^ GEN_POLY[CHK_W-1:0];
    end
    return r;
  endfunction

  function automatic int pop_count(input int unsigned x);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(x[i]);
    return n;
  endfunction

endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/pcc_syndrome.sv
module pcc_syndrome
  import pcc_pkg::*;
(
  input  logic [CW_W-1:0]  word,
  output logic [CHK_W-1:0] syn,
  output logic             par_odd
);

  assign syn     = bch_syndrome(word[CW_W-1:1]);
  assign par_odd = ^word;

endmodule

// File: rtl/pcc_locator.sv
module pcc_locator
  import pcc_pkg::*;
#(
  parameter int BURST_SPAN = 4,
  parameter int BURST_MAX  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CHK_W-1:0] syn,
  input  logic             par_odd,
  input  logic             burst_en,
  output logic [CW_W-1:0]  err_mask,
  output err_class_e       err_class
);

  localparam int NWIN = CW_W - BURST_SPAN + 1;
  localparam int NPAT = 1 << BURST_SPAN;
  localparam int NB   = NWIN * NPAT;

  logic [CHK_W-1:0]           pos_syn [CW_W];
  logic [CW_W-1:0]            single_hit;
  logic [CW_W-1:0][CW_W-1:0]  pair_hit;
  logic [CW_W-1:0]            pair_mask;
  logic [NB-1:0]              burst_hit;
  logic [CW_W-1:0]            burst_pat [NB];
  logic [CW_W-1:0]            burst_mask;
  logic                       single_any, pair_any, burst_any;

  // syndrome of a lone error at each position (parity bit leaves it zero)
  for (genvar k = 0; k < CW_W; k++) begin : gen_pos
    if (k == 0) begin : g_par
      assign pos_syn[k]    = '0;
      assign single_hit[k] = 1'b0;
    end else begin : g_bch
      localparam logic [CHK_W-1:0] S = bch_syndrome(BCH_N'(1) << (k - 1));
      assign pos_syn[k]    = S;
      assign single_hit[k] = (syn == S);
    end
  end

  for (genvar i = 0; i < CW_W; i++) begin : gen_pi
    for (genvar j = 0; j < CW_W; j++) begin : gen_pj
      if (i >= 1 && j > i) begin : g_on
        assign pair_hit[i][j] = (syn == (pos_syn[i] ^ pos_syn[j]));
      end else begin : g_off
        assign pair_hit[i][j] = 1'b0;
      end
    end
  end

  // every pattern in every window; only those of weight 3..BURST_MAX take part
  for (genvar w = 0; w < NWIN; w++) begin : gen_win
    for (genvar p = 0; p < NPAT; p++) begin : gen_pat
      localparam int              IDX = w * NPAT + p;
      localparam logic [CW_W-1:0] M   = CW_W'(p) << w;
      assign burst_pat[IDX] = M;
      if (pop_count(p) > 2 && pop_count(p) <= BURST_MAX) begin : g_use
        localparam logic [CHK_W-1:0] S = bch_syndrome(M[CW_W-1:1]);
        assign burst_hit[IDX] = (syn == S);
      end else begin : g_skip
        assign burst_hit[IDX] = 1'b0;
      end
    end
  end

  always_comb begin
    pair_mask = '0;
    for (int i = 0; i < CW_W; i++) begin
      for (int j = 0; j < CW_W; j++) begin
        if (pair_hit[i][j]) begin
          pair_mask[i] = 1'b1;
          pair_mask[j] = 1'b1;
        end
      end
    end
  end

  // lowest window and pattern index wins
  always_comb begin
    burst_mask = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (burst_hit[b]) burst_mask = burst_pat[b];
    end
  end

  assign single_any = |single_hit;
  assign pair_any   = |pair_hit;
  assign burst_any  = |burst_hit;

  always_comb begin
    err_mask  = '0;
    err_class = ERR_FAIL;
    if (syn == '0) begin
      if (par_odd) begin
        err_mask[0] = 1'b1;
        err_class   = ERR_ONE;
      end else begin
        err_class   = ERR_NONE;
      end
    end else if (single_any) begin
      err_mask = single_hit;
      if (par_odd) begin
        err_class = ERR_ONE;
      end else begin
        err_mask[0] = 1'b1;
        err_class   = ERR_TWO;
      end
    end else if (pair_any && !par_odd) begin
      err_mask  = pair_mask;
      err_class = ERR_TWO;
    end else if (burst_en && par_odd && burst_any) begin
      err_mask  = burst_mask;
      err_class = ERR_BURST;
    end
  end

  assert_single_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(single_hit));
  assert_pair_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_hit));
  assert_burst_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |-> err_class != ERR_BURST);
  assert_one_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_class == ERR_ONE |-> $countones(err_mask) == 1);
  assert_two_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_class == ERR_TWO |-> $countones(err_mask) == 2);
  assert_burst_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_class == ERR_BURST |-> ($countones(err_mask) > 2 && $countones(err_mask) <= BURST_MAX));
  assert_fail_nomask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_class == ERR_FAIL |-> err_mask == '0);

endmodule

// File: rtl/paging_cw_corrector.sv
module paging_cw_corrector
  import pcc_pkg::*;
#(
  parameter int BURST_SPAN = 4,
  parameter int BURST_MAX  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [pcc_pkg::CW_W-1:0] in_word,
  input  logic                    in_is_addr,
  input  logic                    cfg_burst_en,
  output logic                    out_done,
  output logic [pcc_pkg::CW_W-1:0] out_word,
  output logic [2:0]              out_class,
  output logic [1:0]              out_call_type
);

  logic             rst_sn;
  logic             accept;
  logic             busy_q, busy_d;
  logic [CW_W-1:0]  cap_word_q, cap_word_d;
  logic             cap_addr_q, cap_addr_d;
  logic             cap_burst_q, cap_burst_d;
  logic             done_q, done_d;
  logic [CW_W-1:0]  word_q, word_d;
  err_class_e       class_q, class_d;
  logic [1:0]       call_q, call_d;

  logic [CHK_W-1:0] syn;
  logic             par_odd;
  logic [CW_W-1:0]  err_mask;
  err_class_e       err_class;
  logic [CW_W-1:0]  fixed_word;

  pcc_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  pcc_syndrome u_syndrome (
    .word    (cap_word_q),
    .syn     (syn),
    .par_odd (par_odd)
  );

  pcc_locator #(
    .BURST_SPAN (BURST_SPAN),
    .BURST_MAX  (BURST_MAX)
  ) u_locator (
    .clk       (clk),
    .rst_n     (rst_sn),
    .syn       (syn),
    .par_odd   (par_odd),
    .burst_en  (cap_burst_q),
    .err_mask  (err_mask),
    .err_class (err_class)
  );

  assign fixed_word = cap_word_q ^ err_mask;

  always_comb begin
    accept      = in_valid & ~busy_q;
    busy_d      = accept;
    cap_word_d  = cap_word_q;
    cap_addr_d  = cap_addr_q;
    cap_burst_d = cap_burst_q;
    if (accept) begin
      cap_word_d  = in_word;
      cap_addr_d  = in_is_addr;
      cap_burst_d = cfg_burst_en;
    end
    done_d  = busy_q;
    word_d  = word_q;
    class_d = class_q;
    call_d  = call_q;
    if (busy_q) begin
      word_d  = fixed_word;
      class_d = err_class;
      call_d  = cap_addr_q ? fixed_word[CALL_HI:CALL_LO] : 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q      <= 1'b0;
      cap_word_q  <= '0;
      cap_addr_q  <= 1'b0;
      cap_burst_q <= 1'b0;
      done_q      <= 1'b0;
      word_q      <= '0;
      class_q     <= ERR_NONE;
      call_q      <= 2'b00;
    end else begin
      busy_q      <= busy_d;
      cap_word_q  <= cap_word_d;
      cap_addr_q  <= cap_addr_d;
      cap_burst_q <= cap_burst_d;
      done_q      <= done_d;
      word_q      <= word_d;
      class_q     <= class_d;
      call_q      <= call_d;
    end
  end

  assign out_done      = done_q;
  assign out_word      = word_q;
  assign out_class     = class_q;
  assign out_call_type = call_q;

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    out_done |=> !out_done);
  assert_no_early_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && !busy_q) |=> !out_done);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && !busy_q) |=> ##1 out_done);
  assert_is_codeword_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_done && class_q != ERR_FAIL) |->
      (bch_syndrome(out_word[CW_W-1:1]) == '0 && !(^out_word)));
  assert_fail_unchanged_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_done && class_q == ERR_FAIL) |-> out_word == cap_word_q);
  assert_msg_call_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_done && !cap_addr_q) |-> out_call_type == 2'b00);

endmodule

// File: tb/test_paging_cw_corrector.sv
`timescale 1ns/1ps
module test_paging_cw_corrector;

  logic        clk, rst_n, in_valid, in_is_addr, cfg_burst_en;
  logic [31:0] in_word;
  logic        out_done;
  logic [31:0] out_word;
  logic [2:0]  out_class;
  logic [1:0]  out_call_type;

  localparam logic [2:0] C_NONE = 3'b000, C_ONE = 3'b001, C_TWO = 3'b010,
                         C_BURST = 3'b011, C_FAIL = 3'b111;

  typedef struct {
    logic [31:0] w;
    logic [2:0]  c;
    logic [1:0]  t;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk, n_fail;
  bit          finished;
  logic [31:0] rng;

  paging_cw_corrector i_paging_cw_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_is_addr(in_is_addr), .cfg_burst_en(cfg_burst_en), .out_done(out_done),
    .out_word(out_word), .out_class(out_class), .out_call_type(out_call_type)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // data bits d -> word[31:11], check bits by long division, even parity last
  function automatic logic [31:0] make_cw(input logic [20:0] d);
    logic [30:0] rem;
    logic [31:0] w;
    rem = {d, 10'b0};
    for (int i = 30; i >= 10; i--)
      if (rem[i]) rem[i-:11] = rem[i-:11] ^ 11'b11101101001;
    w    = {d, rem[9:0], 1'b0};
    w[0] = ^w[31:1];
    return w;
  endfunction

  task automatic roll(output logic [31:0] r);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r   = rng;
  endtask

  task automatic new_word(input logic addr, output logic [31:0] w);
    logic [31:0] r;
    logic [20:0] d;
    roll(r);
    d     = r[20:0];
    d[20] = ~addr;
    w     = make_cw(d);
  endtask

  // driver: push the expectation, strobe one cycle, check the done timing (R1)
  task automatic send(input logic [31:0] w, input logic addr, input logic ben, input exp_t e);
    @(negedge clk);
    in_word = w; in_is_addr = addr; cfg_burst_en = ben; in_valid = 1'b1;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_done == 1'b0, "R1", "done before latency", 64'(out_done), 64'd0);
    @(negedge clk);
    check(out_done == 1'b1, "R1", "done at latency", 64'(out_done), 64'd1);
  endtask

  task automatic run_case(input logic [31:0] good, input logic [31:0] err, input logic addr,
                          input logic ben, input logic [2:0] cls, input string tag);
    exp_t        e;
    logic [31:0] bad;
    bad   = good ^ err;
    e.w   = (cls == C_FAIL) ? bad : good;
    e.c   = cls;
    e.t   = addr ? e.w[12:11] : 2'b00;
    e.tag = tag;
    send(bad, addr, ben, e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R1", "result with nothing pending", 64'(out_word), 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({out_word, out_class, out_call_type} == {e.w, e.c, e.t}, e.tag,
              "word/class/call", 64'({out_word, out_class, out_call_type}),
              64'({e.w, e.c, e.t}));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] g, w1, w2;
    logic [3:0]  bpat [4];
    exp_t        e;
    bpat[0] = 4'b0111; bpat[1] = 4'b1011; bpat[2] = 4'b1101; bpat[3] = 4'b1110;
    n_chk = 0; n_fail = 0; finished = 0; rng = 32'h1bad_5eed;
    in_valid = 0; in_word = '0; in_is_addr = 0; cfg_burst_en = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check(out_done == 0, "R9", "done after reset", 64'(out_done), 64'd0);
    check(out_word == 0, "R9", "word after reset", 64'(out_word), 64'd0);
    check(out_class == 0, "R9", "class after reset", 64'(out_class), 64'd0);
    check(out_call_type == 0, "R9", "call after reset", 64'(out_call_type), 64'd0);

    // R2 clean words; R7 every call type on address words; R8 message words
    for (int t = 0; t < 4; t++) begin
      new_word(1'b1, g);
      g[31:11] = {g[31:13], 2'(t)};
      g = make_cw(g[31:11]);
      run_case(g, 32'd0, 1'b1, 1'b0, C_NONE, (t == 0) ? "R2" : "R7");
    end
    for (int t = 0; t < 2; t++) begin
      new_word(1'b0, g);
      run_case(g, 32'd0, 1'b0, 1'(t), C_NONE, "R8");
    end

    // R3 single error at every position (burst enabled on odd ones: R10)
    for (int k = 0; k < 32; k++) begin
      new_word(1'(k & 1), g);
      run_case(g, 32'd1 << k, 1'(k & 1), 1'(k & 1), C_ONE, k[0] ? "R10" : "R3");
    end

    // R4 two errors, pairs spread over the word including the parity bit
    for (int k = 0; k < 32; k++) begin
      int j;
      j = (k + 1 + (k * 5) % 31) % 32;
      new_word(1'(k >> 1), g);
      run_case(g, (32'd1 << k) | (32'd1 << j), 1'(k >> 1), 1'(k >> 1), C_TWO,
               k[1] ? "R10" : "R4");
    end

    // R5 three errors in a four-bit window, burst correction on
    for (int w = 0; w <= 28; w++) begin
      for (int p = 0; p < 4; p++) begin
        new_word(1'(p & 1), g);
        run_case(g, 32'(bpat[p]) << w, 1'(p & 1), 1'b1, C_BURST, "R5");
      end
    end

    // R6 same patterns with burst correction off, plus scattered triples
    for (int w = 0; w <= 28; w += 2) begin
      new_word(1'b1, g);
      run_case(g, 32'(bpat[w % 4]) << w, 1'b1, 1'b0, C_FAIL, "R6");
    end
    new_word(1'b1, g);
    run_case(g, 32'h8000_8001, 1'b1, 1'b0, C_FAIL, "R6");
    new_word(1'b0, g);
    run_case(g, 32'h0104_0100, 1'b0, 1'b0, C_FAIL, "R6");

    // R1 strobe while a word is pending is ignored
    new_word(1'b1, w1);
    new_word(1'b1, w2);
    w2 = w2 ^ 32'h0000_0010;
    @(negedge clk);
    in_word = w1; in_is_addr = 1'b1; cfg_burst_en = 1'b0; in_valid = 1'b1;
    e.w = w1; e.c = C_NONE; e.t = w1[12:11]; e.tag = "R1";
    sb_q.push_back(e);
    @(negedge clk);
    in_word = w2;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_done == 1'b1, "R1", "first word done", 64'(out_done), 64'd1);
    @(negedge clk);
    check(out_done == 1'b0, "R1", "ignored word produced no done", 64'(out_done), 64'd0);
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R1", "results outstanding", 64'(sb_q.size()), 64'd0);

    finished = 1;
    summary();
    $finish;
  end

endmodule